// File: doc/BRIEF.md
# Address-Block Access Control Matcher

This block classifies every bus access against a small set of address windows. Each window is described by one 32-bit control word. The word gives an 8-bit tag that is compared against the top byte of the address, an 8-bit ignore mask, an enable, a privilege qualifier, two free user attribute bits, a cache-mode code and a write-protect flag. A window therefore covers at least 16 MB. Setting mask bits widens a window, and the resulting region does not have to be contiguous.

Software loads the control words through a small configuration port. Only supervisor-mode cycles can write or read that port. For each access the block receives the address, a supervisor flag and a write flag. One clock later it reports whether a window matched and which one. It also reports that window's attributes, or the default attributes when nothing matched. A write that lands in a protected window raises a fault pulse, and its write enable is withheld. When several windows match, the one with the lowest index decides the outcome.

Top module: `acc_window_match`

## Requirements
- R1: After reset every control word is zero, a supervisor read of either word returns 0, and every access reports no match.
- R2: A configuration cycle with cfg_sel=1, cfg_we=1 and cfg_super=1 stores cfg_wdata AND 32'hFFFF_E364 into word cfg_idx. The kept fields are: tag [31:24], ignore mask [23:16], enable [15], privilege mode [14:13], user bits [9:8], cache mode [6:5] and write protect [2]. A cycle with cfg_sel=1, cfg_we=0 and cfg_super=1 returns the stored word on cfg_rdata in the same cycle.
- R3: A configuration write with cfg_super=0 leaves the stored word unchanged. A configuration read with cfg_super=0 returns 0.
- R4: A window matches only when, for every bit i of 0..7 with ignore-mask bit i equal to 0, address bit 24+i equals tag bit i. Masked bits are free, so non-contiguous regions are possible.
- R5: A window whose enable bit is 0 never matches.
- R6: Privilege mode 00 matches only accesses with acc_super=0. Mode 01 matches only accesses with acc_super=1. Modes 10 and 11 match either.
- R7: On a match, hit_none=0, hit_idx holds the lowest-numbered matching window, and hit_user, hit_cmode and hit_wprot carry that window's fields.
- R8: A matched write with write protect set gives wr_fault=1 and wr_en_out=0. Any other write gives wr_en_out=1 and wr_fault=0. A read gives both 0.
- R9: With no match: hit_none=1, hit_idx=0, hit_user=00, hit_cmode=01 (cacheable copyback), hit_wprot=0.
- R10: All access outputs are registered and describe the access sampled at the previous rising edge. When acc_valid was 0, hit_valid, wr_fault and wr_en_out are 0 and the other outputs hold the R9 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Configuration cycle select |
| cfg_we | input | 1 | Configuration write (1) or read (0) |
| cfg_super | input | 1 | Configuration cycle is supervisor mode |
| cfg_idx | input | IDX_W | Control word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_super | input | 1 | Access is supervisor mode |
| acc_write | input | 1 | Access is a write |
| hit_valid | output | 1 | Result is for a valid access |
| hit_none | output | 1 | No window matched |
| hit_idx | output | IDX_W | Index of the selected window |
| hit_user | output | 2 | User attribute bits of the selected window |
| hit_cmode | output | 2 | Cache mode of the selected window |
| hit_wprot | output | 1 | Selected window is write protected |
| wr_fault | output | 1 | Write to a protected window |
| wr_en_out | output | 1 | Permitted write enable |

## Verification
The bench builds the block with its defaults: two windows and a 32-bit address. At this size every value of the compared address byte can be swept, in all four combinations of privilege and direction, under each of several window settings. Those settings include disabled windows, every privilege code, a non-contiguous mask, full overlap and a protected window. Each result is predicted arithmetically from the written control words, so the priority, mode and fault rules are covered over the full tag space rather than at a few spot addresses.

// File: rtl/acw_pkg.sv
package acw_pkg;

    localparam int WORD_W = 32;
    localparam int TAG_W  = 8;

    // bits that survive a configuration write
    localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFFFF_E364;

    // cache mode reported when no window matches (cacheable copyback)
    localparam logic [1:0] CM_DEFAULT = 2'b01;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] ign;
        logic             en;
        logic [1:0]       priv;
        logic [1:0]       usr;
        logic [1:0]       cm;
        logic             wp;
    } win_cfg_t;

    function automatic win_cfg_t split_word(input logic [WORD_W-1:0] w);
        win_cfg_t c;
        c.tag  = w[31:24];
        c.ign  = w[23:16];
        c.en   = w[15];
        c.priv = w[14:13];
        c.usr  = w[9:8];
        c.cm   = w[6:5];
        c.wp   = w[2];
        return c;
    endfunction

endpackage

// File: rtl/acw_cfg_regs.sv
module acw_cfg_regs
    import acw_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_sel,
    input  logic                      cfg_we,
    input  logic                      cfg_super,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [WORD_W-1:0]         cfg_wdata,
    output logic [WORD_W-1:0]         cfg_rdata,
    output logic [NUM_WIN*WORD_W-1:0] win_words
);

    typedef struct packed {
        logic [NUM_WIN-1:0][WORD_W-1:0] word;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  idx_ok;

    assign idx_ok = (int'(cfg_idx) < NUM_WIN);

    always_comb begin
        regs_d = regs_q;
        if (cfg_sel && cfg_we && cfg_super && idx_ok) begin
            regs_d.word[cfg_idx] = cfg_wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel && !cfg_we && cfg_super && idx_ok) begin
            cfg_rdata = regs_q.word[cfg_idx];
        end
    end

    assign win_words = regs_q.word;

endmodule

// File: rtl/acw_win_match.sv
module acw_win_match
    import acw_pkg::*;
(
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic              acc_super,
    output logic              hit,
    output win_cfg_t          fields
);

    logic tag_ok;
    logic priv_ok;

    always_comb begin
        fields  = split_word(cfg_word);
        tag_ok  = ((addr_tag ^ fields.tag) & ~fields.ign) == '0;
        priv_ok = fields.priv[1] || (fields.priv[0] == acc_super);
        hit     = fields.en && tag_ok && priv_ok;
    end

endmodule

// File: rtl/acw_pick.sv
module acw_pick #(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = |hits;
        idx = '0;
        // scan downward so the lowest index is the last to win
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/acc_window_match.sv
module acc_window_match
    import acw_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic              cfg_super,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              acc_write,
    output logic              hit_valid,
    output logic              hit_none,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [1:0]        hit_user,
    output logic [1:0]        hit_cmode,
    output logic              hit_wprot,
    output logic              wr_fault,
    output logic              wr_en_out
);

    typedef struct packed {
        logic             valid;
        logic             none;
        logic [IDX_W-1:0] idx;
        logic [1:0]       usr;
        logic [1:0]       cm;
        logic             wp;
        logic             fault;
        logic             wen;
    } res_t;

    logic [NUM_WIN*WORD_W-1:0] win_words;
    logic [NUM_WIN-1:0]        win_hit;
    win_cfg_t                  win_f [NUM_WIN];
    logic                      any_hit;
    logic [IDX_W-1:0]          sel_idx;
    logic [TAG_W-1:0]          addr_tag;

    res_t res_d, res_q;

    assign addr_tag = acc_addr[ADDR_W-1 -: TAG_W];

    acw_cfg_regs #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_we    (cfg_we),
        .cfg_super (cfg_super),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_words (win_words)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        acw_win_match i_match (
            .cfg_word  (win_words[g*WORD_W +: WORD_W]),
            .addr_tag  (addr_tag),
            .acc_super (acc_super),
            .hit       (win_hit[g]),
            .fields    (win_f[g])
        );
    end

    acw_pick #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) i_pick (
        .hits (win_hit),
        .any  (any_hit),
        .idx  (sel_idx)
    );

    always_comb begin
        res_d      = '0;
        res_d.none = 1'b1;
        res_d.cm   = CM_DEFAULT;
        if (acc_valid) begin
            res_d.valid = 1'b1;
            if (any_hit) begin
                res_d.none = 1'b0;
                res_d.idx  = sel_idx;
                res_d.usr  = win_f[sel_idx].usr;
                res_d.cm   = win_f[sel_idx].cm;
                res_d.wp   = win_f[sel_idx].wp;
            end
            res_d.fault = acc_write && res_d.wp;
            res_d.wen   = acc_write && !res_d.wp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.none <= 1'b1;
            res_q.cm   <= CM_DEFAULT;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_valid = res_q.valid;
    assign hit_none  = res_q.none;
    assign hit_idx   = res_q.idx;
    assign hit_user  = res_q.usr;
    assign hit_cmode = res_q.cm;
    assign hit_wprot = res_q.wp;
    assign wr_fault  = res_q.fault;
    assign wr_en_out = res_q.wen;

endmodule

// File: rtl/acw_match_chk.sv
module acw_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        cfg_we,
    input logic        cfg_super,
    input logic [31:0] cfg_rdata,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        hit_valid,
    input logic        hit_none,
    input logic [1:0]  hit_user,
    input logic [1:0]  hit_cmode,
    input logic        hit_wprot,
    input logic        wr_fault,
    input logic        wr_en_out
);

    // R3
    user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && !cfg_we && !cfg_super) |-> (cfg_rdata == 32'h0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~32'hFFFF_E364) == 32'h0);

    // R8
    fault_blocks_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> (!wr_en_out && hit_wprot && !hit_none));

    // R8
    fault_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fault || wr_en_out) |-> $past(acc_write));

    // R9
    none_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_none |-> (hit_user == 2'b00 && hit_cmode == 2'b01 && !hit_wprot));

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid == $past(acc_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> (!wr_fault && !wr_en_out && hit_none));

endmodule

bind acc_window_match acw_match_chk u_acw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_we    (cfg_we),
    .cfg_super (cfg_super),
    .cfg_rdata (cfg_rdata),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .hit_valid (hit_valid),
    .hit_none  (hit_none),
    .hit_user  (hit_user),
    .hit_cmode (hit_cmode),
    .hit_wprot (hit_wprot),
    .wr_fault  (wr_fault),
    .wr_en_out (wr_en_out)
);

// File: tb/test_acc_window_match.sv
`timescale 1ns/1ps
module test_acc_window_match;

    localparam logic [31:0] KEEP  = 32'hFFFF_E364;
    localparam logic [31:0] JUNK  = 32'h0000_1C9B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0, cfg_super = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0, acc_super = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        hit_valid, hit_none, hit_wprot, wr_fault, wr_en_out;
    logic [0:0]  hit_idx;
    logic [1:0]  hit_user, hit_cmode;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [2];

    always #4 clk = ~clk;

    acc_window_match i_acc_window_match (
        .clk (clk), .rst_n (rst_n),
        .cfg_sel (cfg_sel), .cfg_we (cfg_we), .cfg_super (cfg_super),
        .cfg_idx (cfg_idx), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .acc_valid (acc_valid), .acc_addr (acc_addr),
        .acc_super (acc_super), .acc_write (acc_write),
        .hit_valid (hit_valid), .hit_none (hit_none), .hit_idx (hit_idx),
        .hit_user (hit_user), .hit_cmode (hit_cmode), .hit_wprot (hit_wprot),
        .wr_fault (wr_fault), .wr_en_out (wr_en_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] tag, input logic [7:0] ign,
                                       input logic en, input logic [1:0] pm,
                                       input logic [1:0] usr, input logic [1:0] cm,
                                       input logic wp);
        return {tag, ign, en, pm, 3'b000, usr, 1'b0, cm, 2'b00, wp, 2'b00};
    endfunction

    function automatic logic hits(input logic [31:0] w, input logic [7:0] b, input logic s);
        logic tag_ok, pm_ok;
        tag_ok = ((b ^ w[31:24]) & ~w[23:16]) == 8'h00;
        pm_ok  = (w[14:13] == 2'b10) || (w[14:13] == 2'b11) ||
                 (w[14:13] == 2'b00 && !s) || (w[14:13] == 2'b01 && s);
        return w[15] && tag_ok && pm_ok;
    endfunction

    task automatic cfg_wr(input logic idx, input logic sup, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b1; cfg_super = sup;
        cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_we = 1'b0; cfg_super = 1'b0;
        if (sup) model[idx] = d & KEEP;
    endtask

    task automatic cfg_rd(input logic idx, input logic sup, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b0; cfg_super = sup; cfg_idx = idx;
        #1;
        d = cfg_rdata;
        cfg_sel = 1'b0; cfg_super = 1'b0;
    endtask

    task automatic access(input logic [7:0] b, input logic s, input logic wr);
        logic h0, h1, any, wp;
        logic [1:0] ex_usr, ex_cm;
        logic ex_idx;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = {b, b ^ 8'h5A, ~b, 8'hC3};
        acc_super = s;
        acc_write = wr;
        @(posedge clk);
        #2;
        acc_valid = 1'b0;
        h0 = hits(model[0], b, s);
        h1 = hits(model[1], b, s);
        any = h0 || h1;
        ex_idx = !h0 && h1;
        ex_usr = any ? model[ex_idx][9:8] : 2'b00;
        ex_cm  = any ? model[ex_idx][6:5] : 2'b01;
        wp     = any ? model[ex_idx][2] : 1'b0;
        // R4 R5 R6 R7: match decision and window selection
        chk("R4 R5 R6 R7 match", {30'd0, hit_none, hit_idx}, {30'd0, !any, any ? ex_idx : 1'b0});
        // R7 R9: attributes
        chk("R7 R9 attrs", {27'd0, hit_user, hit_cmode, hit_wprot}, {27'd0, ex_usr, ex_cm, wp});
        // R8 R10: write result
        chk("R8 R10 write", {29'd0, hit_valid, wr_fault, wr_en_out},
            {29'd0, 1'b1, wr && wp, wr && !wp});
    endtask

    task automatic sweep();
        for (int b = 0; b < 256; b++) begin
            for (int m = 0; m < 4; m++) begin
                access(8'(b), m[0], m[1]);
            end
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        model[0] = '0;
        model[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cfg_rd(1'b0, 1'b1, rd); chk("R1 word0", rd, 32'h0);
        cfg_rd(1'b1, 1'b1, rd); chk("R1 word1", rd, 32'h0);
        @(negedge clk);
        chk("R1 idle", {29'd0, hit_valid, hit_none, wr_en_out}, {29'd0, 1'b0, 1'b1, 1'b0});
        access(8'h00, 1'b1, 1'b1);
        chk("R1 nomatch", {31'd0, hit_none}, 32'd1);

        // R2: write with reserved junk, read back masked
        cfg_wr(1'b0, 1'b1, mk(8'h40, 8'h00, 1'b1, 2'b00, 2'b01, 2'b10, 1'b0) | JUNK);
        cfg_wr(1'b1, 1'b1, mk(8'h40, 8'hFF, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1) | JUNK);
        cfg_rd(1'b0, 1'b1, rd); chk("R2 readback0", rd, model[0]);
        cfg_rd(1'b1, 1'b1, rd); chk("R2 readback1", rd, model[1]);
        chk("R2 mask", model[1], 32'h40FF_6364);

        // R3: user-mode write ignored, user read zero
        cfg_wr(1'b1, 1'b0, 32'hFFFF_FFFF);
        cfg_rd(1'b1, 1'b1, rd); chk("R3 write ignored", rd, model[1]);
        cfg_rd(1'b0, 1'b0, rd); chk("R3 user read", rd, 32'h0);

        // R4 R5 R6: exact tag, user only; window 1 disabled
        sweep();

        // R4 R6: masked + supervisor-only protected, non-contiguous either-mode
        cfg_wr(1'b0, 1'b1, mk(8'h80, 8'h0F, 1'b1, 2'b01, 2'b10, 2'b11, 1'b1));
        cfg_wr(1'b1, 1'b1, mk(8'h10, 8'h81, 1'b1, 2'b10, 2'b11, 2'b00, 1'b0));
        sweep();

        // R7: full overlap, window 0 covers everything
        cfg_wr(1'b0, 1'b1, mk(8'h00, 8'hFF, 1'b1, 2'b11, 2'b01, 2'b00, 1'b0));
        cfg_wr(1'b1, 1'b1, mk(8'h33, 8'h00, 1'b1, 2'b11, 2'b10, 2'b10, 1'b1));
        sweep();

        // R6 R8: same region split by privilege
        cfg_wr(1'b0, 1'b1, mk(8'hA5, 8'h18, 1'b1, 2'b01, 2'b00, 2'b10, 1'b1));
        cfg_wr(1'b1, 1'b1, mk(8'hA5, 8'h00, 1'b1, 2'b00, 2'b11, 2'b11, 1'b0));
        sweep();

        // R5: both disabled with full masks and either-mode
        cfg_wr(1'b0, 1'b1, mk(8'h00, 8'hFF, 1'b0, 2'b10, 2'b11, 2'b11, 1'b1));
        cfg_wr(1'b1, 1'b1, mk(8'hFF, 8'hFF, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1));
        sweep();

        // R10: idle cycle after traffic
        @(negedge clk);
        @(negedge clk);
        chk("R10 idle", {29'd0, hit_valid, wr_fault, wr_en_out}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule